// File: doc/BRIEF.md
# Converter Calibration Mode Sequencer

This block steps a converter through its operating modes: plain conversion, a one-step self-calibration, a zero-scale system calibration and a full-scale system calibration. Software writes a mode code, a channel code and a gain code in one register write. The sequencer then issues zero-scale and full-scale measurement strobes to the conversion engine and counts output-rate ticks until each measurement returns. It stores each measurement as an offset or gain coefficient in one of three coefficient pairs. When the sequence ends, it clears the mode code by itself.

The same block owns the active-low data-ready flag. The flag is raised when a calibration begins. It drops when a fresh word reaches the data register, either at the end of a calibration or with each normal conversion. A filter-hold input keeps the sequencing logic in reset without disturbing the flag. A standby input freezes all state. The conversion engine is modelled by a stub that returns a deterministic value a parameterised number of ticks after each strobe.

Top module: `cal_seq`

## Requirements
- R1: After reset, `rdy_n` is 1, `mode_out` is 00, and `zs_start`, `fs_start`, `coef_wr` and `dat_load` are 0.
- R2: Mode code 01 issues a zero-scale strobe and then a full-scale strobe. Code 10 issues only a zero-scale strobe, and code 11 issues only a full-scale strobe. Each measurement finishes after exactly MEAS_TICKS `rate_tick` pulses that follow its strobe.
- R3: `rdy_n` is 1 in the cycle a calibration strobe first appears. It stays 1 until the final coefficient write. It is 0, with `dat_load` pulsing, in the same cycle as that final write.
- R4: In the cycle of the final coefficient write, `mode_out` returns to 00. Normal conversion then restarts, and the first `dat_load` comes on the SETTLE_TICKS-th tick after completion.
- R5: A zero-scale result is written with `coef_is_gain`=0, and a full-scale result with `coef_is_gain`=1. `coef_pair` is 0 for channel codes 00 and 10, 1 for code 01, and 2 for code 11.
- R6: The stored value is BASE·2^gain + pair. BASE is ZS_BASE for zero-scale and FS_BASE for full-scale, and gain is the 3-bit gain code (gain 1 to 128).
- R7: While `fsync` is 1, no `dat_load` and no calibration strobe occurs, and `rdy_n` does not rise if it is 0. A mode written during the hold starts its sequence in the cycle after `fsync` falls.
- R8: In normal mode, once settled, each tick pulses `dat_load` and drives `rdy_n` to 0. A `rd_done` pulse drives `rdy_n` back to 1.
- R9: A mode write during a calibration abandons it without writing a coefficient. The new mode then runs from its first step.
- R10: While `standby` is 1, ticks and mode writes are ignored and all state holds. The sequence resumes where it stopped once `standby` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| standby | input | 1 | Freeze all sequencing state |
| fsync | input | 1 | Hold filter/calibration logic in reset |
| mode_wr | input | 1 | Register write strobe for mode, channel, gain |
| mode_in | input | 2 | Mode code: 00 normal, 01 self, 10 zero-scale system, 11 full-scale system |
| chan_in | input | 2 | Channel code |
| gain_in | input | 3 | Gain code, gain = 2^code |
| rate_tick | input | 1 | Output-rate tick from the conversion engine |
| rd_done | input | 1 | Data register fully read |
| rdy_n | output | 1 | Data-ready flag, 0 = new word available |
| mode_out | output | 2 | Current mode field |
| zs_start | output | 1 | Zero-scale measurement strobe |
| fs_start | output | 1 | Full-scale measurement strobe |
| dat_load | output | 1 | New word loaded into the data register |
| coef_wr | output | 1 | Coefficient write strobe |
| coef_is_gain | output | 1 | 1 = gain coefficient, 0 = offset coefficient |
| coef_pair | output | 2 | Target coefficient pair (0 to 2) |
| coef_val | output | RES_W | Coefficient value |

## Verification
The assertions assume that `rate_tick` is a single-cycle pulse. They also assume that `rd_done` is never asserted together with `fsync` on a flag that must stay low. The stimulus keeps ticks at least three cycles apart, so a result never arrives in the same cycle as the next tick. It pulses `rd_done` only in the directed normal-mode phase, away from any hold. Random runs draw mode, channel and gain codes from a fixed seed across all legal values. Directed runs cover the filter hold, a mid-calibration abort and a standby freeze.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

   typedef enum logic [1:0] {
      MD_NORMAL = 2'b00,
      MD_SELF   = 2'b01,
      MD_ZSYS   = 2'b10,
      MD_FSYS   = 2'b11
   } cal_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ZS   = 2'd1,
      ST_FS   = 2'd2
   } seq_st_e;

   // channel code to coefficient pair; codes 00 and 10 share pair 0
   function automatic logic [1:0] pair_of(input logic [1:0] chan);
      case (chan)
         2'b01:   pair_of = 2'd1;
         2'b11:   pair_of = 2'd2;
         default: pair_of = 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/cal_meas_stub.sv
module cal_meas_stub #(
   parameter int RES_W = 24,
   parameter int MEAS_TICKS = 4,
   parameter logic [RES_W-1:0] ZS_BASE = 'h10,
   parameter logic [RES_W-1:0] FS_BASE = 'h1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             clr,
   input  logic             start,
   input  logic             start_fs,
   input  logic             tick,
   input  logic [2:0]       gain,
   input  logic [1:0]       pair,
   output logic             res_vld,
   output logic [RES_W-1:0] res_val
);

   logic       busy;
   logic       kind_fs;
   logic [2:0] gain_q;
   logic [1:0] pair_q;
   logic       last_tick;

   generate
      if (MEAS_TICKS == 1) begin : g_single
         assign last_tick = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(MEAS_TICKS);
         localparam logic [CW-1:0] LAST = CW'(MEAS_TICKS - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (en) begin
               if (clr || start)      cnt <= '0;
               else if (busy && tick) cnt <= cnt + 1'b1;
            end
         end
         assign last_tick = (cnt == LAST);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         kind_fs <= 1'b0;
         gain_q  <= '0;
         pair_q  <= '0;
         res_vld <= 1'b0;
         res_val <= '0;
      end else if (en) begin
         res_vld <= 1'b0;
         if (clr) begin
            busy <= 1'b0;
         end else if (start) begin
            busy    <= 1'b1;
            kind_fs <= start_fs;
            gain_q  <= gain;
            pair_q  <= pair;
         end else if (busy && tick && last_tick) begin
            busy    <= 1'b0;
            res_vld <= 1'b1;
            res_val <= ((kind_fs ? FS_BASE : ZS_BASE) << gain_q) + RES_W'(pair_q);
         end
      end
   end

   // a fresh result only follows a tick (R2)
   assert_res_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(res_vld) |-> $past(tick));

endmodule

// File: rtl/cal_seq_fsm.sv
module cal_seq_fsm
   import cal_seq_pkg::*;
#(
   parameter int SETTLE_TICKS = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       standby,
   input  logic       fsync,
   input  logic       mode_wr,
   input  logic [1:0] mode_in,
   input  logic [1:0] chan_in,
   input  logic [2:0] gain_in,
   input  logic       tick,
   input  logic       rd_done,
   input  logic       res_vld,
   output cal_mode_e  mode_q,
   output logic [1:0] chan_q,
   output logic [2:0] gain_q,
   output logic       rdy_n,
   output logic       zs_start,
   output logic       fs_start,
   output logic       dat_load,
   output logic       cal_wr,
   output logic       cal_gain,
   output logic       stub_start,
   output logic       stub_start_fs,
   output logic       stub_clr
);

   localparam int SW = (SETTLE_TICKS > 1) ? $clog2(SETTLE_TICKS) : 1;
   localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_TICKS - 1);

   seq_st_e       st;
   logic [SW-1:0] settle;
   logic          start_any;
   logic          chain_fs;

   assign start_any     = (st == ST_IDLE) && (mode_q != MD_NORMAL) && !fsync && !mode_wr;
   assign chain_fs      = (st == ST_ZS) && res_vld && (mode_q == MD_SELF) && !fsync && !mode_wr;
   assign stub_start    = start_any || chain_fs;
   assign stub_start_fs = chain_fs || (mode_q == MD_FSYS);
   assign stub_clr      = fsync || mode_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         mode_q   <= MD_NORMAL;
         chan_q   <= '0;
         gain_q   <= '0;
         settle   <= '0;
         rdy_n    <= 1'b1;
         zs_start <= 1'b0;
         fs_start <= 1'b0;
         dat_load <= 1'b0;
         cal_wr   <= 1'b0;
         cal_gain <= 1'b0;
      end else if (!standby) begin
         zs_start <= 1'b0;
         fs_start <= 1'b0;
         dat_load <= 1'b0;
         cal_wr   <= 1'b0;
         if (rd_done) rdy_n <= 1'b1;
         if (mode_wr) begin
            mode_q <= cal_mode_e'(mode_in);
            chan_q <= chan_in;
            gain_q <= gain_in;
            st     <= ST_IDLE;
            settle <= '0;
         end else if (fsync) begin
            st     <= ST_IDLE;
            settle <= '0;
         end else begin
            case (st)
               ST_IDLE: begin
                  if (mode_q != MD_NORMAL) begin
                     st       <= (mode_q == MD_FSYS) ? ST_FS : ST_ZS;
                     zs_start <= (mode_q != MD_FSYS);
                     fs_start <= (mode_q == MD_FSYS);
                     rdy_n    <= 1'b1;
                  end else if (tick) begin
                     if (settle == SETTLE_LAST) begin
                        dat_load <= 1'b1;
                        rdy_n    <= 1'b0;
                     end else begin
                        settle <= settle + 1'b1;
                     end
                  end
               end
               ST_ZS: begin
                  if (res_vld) begin
                     cal_wr   <= 1'b1;
                     cal_gain <= 1'b0;
                     if (mode_q == MD_SELF) begin
                        st       <= ST_FS;
                        fs_start <= 1'b1;
                     end else begin
                        st       <= ST_IDLE;
                        mode_q   <= MD_NORMAL;
                        rdy_n    <= 1'b0;
                        dat_load <= 1'b1;
                        settle   <= '0;
                     end
                  end
               end
               ST_FS: begin
                  if (res_vld) begin
                     cal_wr   <= 1'b1;
                     cal_gain <= 1'b1;
                     st       <= ST_IDLE;
                     mode_q   <= MD_NORMAL;
                     rdy_n    <= 1'b0;
                     dat_load <= 1'b1;
                     settle   <= '0;
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(zs_start && fs_start));

   assert_rdy_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (zs_start || fs_start) |-> rdy_n);

   assert_fsync_keeps_rdy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fsync && !rdy_n && !rd_done && !standby) |=> !rdy_n);

   assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      standby |=> ($stable(mode_q) && $stable(rdy_n) && $stable(st)));

endmodule

// File: rtl/cal_seq.sv
module cal_seq
   import cal_seq_pkg::*;
#(
   parameter int RES_W = 24,
   parameter int MEAS_TICKS = 4,
   parameter int SETTLE_TICKS = 3,
   parameter logic [RES_W-1:0] ZS_BASE = 'h10,
   parameter logic [RES_W-1:0] FS_BASE = 'h1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             standby,
   input  logic             fsync,
   input  logic             mode_wr,
   input  logic [1:0]       mode_in,
   input  logic [1:0]       chan_in,
   input  logic [2:0]       gain_in,
   input  logic             rate_tick,
   input  logic             rd_done,
   output logic             rdy_n,
   output logic [1:0]       mode_out,
   output logic             zs_start,
   output logic             fs_start,
   output logic             dat_load,
   output logic             coef_wr,
   output logic             coef_is_gain,
   output logic [1:0]       coef_pair,
   output logic [RES_W-1:0] coef_val
);

   generate
      if (MEAS_TICKS < 1) begin : g_bad_meas
         $error("MEAS_TICKS must be at least 1");
      end
      if (SETTLE_TICKS < 1) begin : g_bad_settle
         $error("SETTLE_TICKS must be at least 1");
      end
      if (RES_W < 8 || RES_W > 62) begin : g_bad_width
         $error("RES_W must lie in 8..62");
      end else if ((longint'(FS_BASE) << 7) + 64'd3 >= (longint'(1) << RES_W)) begin : g_bad_base
         $error("FS_BASE scaled by the largest gain does not fit RES_W");
      end
   endgenerate

   cal_mode_e  mode_q;
   logic [1:0] chan_q;
   logic [2:0] gain_q;
   logic       res_vld;
   logic       stub_start, stub_start_fs, stub_clr;

   cal_seq_fsm #(
      .SETTLE_TICKS (SETTLE_TICKS)
   ) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .standby       (standby),
      .fsync         (fsync),
      .mode_wr       (mode_wr),
      .mode_in       (mode_in),
      .chan_in       (chan_in),
      .gain_in       (gain_in),
      .tick          (rate_tick),
      .rd_done       (rd_done),
      .res_vld       (res_vld),
      .mode_q        (mode_q),
      .chan_q        (chan_q),
      .gain_q        (gain_q),
      .rdy_n         (rdy_n),
      .zs_start      (zs_start),
      .fs_start      (fs_start),
      .dat_load      (dat_load),
      .cal_wr        (coef_wr),
      .cal_gain      (coef_is_gain),
      .stub_start    (stub_start),
      .stub_start_fs (stub_start_fs),
      .stub_clr      (stub_clr)
   );

   cal_meas_stub #(
      .RES_W      (RES_W),
      .MEAS_TICKS (MEAS_TICKS),
      .ZS_BASE    (ZS_BASE),
      .FS_BASE    (FS_BASE)
   ) u_stub (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (!standby),
      .clr      (stub_clr),
      .start    (stub_start),
      .start_fs (stub_start_fs),
      .tick     (rate_tick),
      .gain     (gain_q),
      .pair     (pair_of(chan_q)),
      .res_vld  (res_vld),
      .res_val  (coef_val)
   );

   assign mode_out  = mode_q;
   assign coef_pair = pair_of(chan_q);

   // final write closes the sequence: mode cleared, word loaded, flag low (R4, R3)
   assert_final_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (coef_wr && !fs_start) |-> (mode_out == 2'b00 && !rdy_n && dat_load));

   assert_pair_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      coef_wr |-> (coef_pair != 2'd3));

endmodule

// File: tb/cal_seq_tb.sv
`timescale 1ns/1ps
module cal_seq_tb;

   localparam int RES_W  = 24;
   localparam int MEAS   = 4;
   localparam int SETTLE = 3;
   localparam logic [RES_W-1:0] ZSB = 24'h10;
   localparam logic [RES_W-1:0] FSB = 24'h1000;

   logic clk = 1'b0, rst_n = 1'b0, standby = 1'b0, fsync = 1'b0;
   logic mode_wr = 1'b0, tick = 1'b0, rd_done = 1'b0;
   logic [1:0] mode_in = '0, chan_in = '0;
   logic [2:0] gain_in = '0;
   logic rdy_n, zs_start, fs_start, dat_load, coef_wr, coef_is_gain;
   logic [1:0] mode_out, coef_pair;
   logic [RES_W-1:0] coef_val;

   always #2.5 clk = ~clk;

   cal_seq #(.RES_W(RES_W), .MEAS_TICKS(MEAS), .SETTLE_TICKS(SETTLE),
             .ZS_BASE(ZSB), .FS_BASE(FSB)) u_dut (
      .clk(clk), .rst_n(rst_n), .standby(standby), .fsync(fsync),
      .mode_wr(mode_wr), .mode_in(mode_in), .chan_in(chan_in), .gain_in(gain_in),
      .rate_tick(tick), .rd_done(rd_done), .rdy_n(rdy_n), .mode_out(mode_out),
      .zs_start(zs_start), .fs_start(fs_start), .dat_load(dat_load),
      .coef_wr(coef_wr), .coef_is_gain(coef_is_gain), .coef_pair(coef_pair),
      .coef_val(coef_val));

   int n_chk = 0, n_err = 0;
   bit finished = 0;

   int n_zs, n_fs, n_wr, n_load, ticks_since;
   bit in_cal, rdy_start_bad, rdy_mid_bad, done;
   bit wr_gain [4];
   int wr_pair [4];
   logic [RES_W-1:0] wr_val [4];
   int wr_ticks [4];
   logic [1:0] done_mode;
   logic done_rdy, done_load;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_pair(input logic [1:0] c);
      return (c == 2'b01) ? 1 : (c == 2'b11) ? 2 : 0;
   endfunction

   function automatic logic [RES_W-1:0] exp_val(input bit fs, input logic [2:0] g, input logic [1:0] c);
      return ((fs ? FSB : ZSB) << g) + RES_W'(exp_pair(c));
   endfunction

   task automatic clear_tally();
      n_zs = 0; n_fs = 0; n_wr = 0; n_load = 0; ticks_since = 0;
      in_cal = 0; rdy_start_bad = 0; rdy_mid_bad = 0; done = 0;
      for (int i = 0; i < 4; i++) begin
         wr_gain[i] = 0; wr_pair[i] = -1; wr_val[i] = '0; wr_ticks[i] = -1;
      end
   endtask

   task automatic cyc(input bit t, input bit rd);
      tick = t; rd_done = rd;
      @(posedge clk); #1;
      tick = 0; rd_done = 0;
      if (t && !standby) ticks_since++;
      if (dat_load) n_load++;
      if (coef_wr) begin
         if (n_wr < 4) begin
            wr_gain[n_wr] = coef_is_gain; wr_pair[n_wr] = int'(coef_pair);
            wr_val[n_wr] = coef_val; wr_ticks[n_wr] = ticks_since;
         end
         n_wr++;
         if (!fs_start) begin
            done = 1; in_cal = 0;
            done_mode = mode_out; done_rdy = rdy_n; done_load = dat_load;
         end
      end
      if (in_cal && !rdy_n) rdy_mid_bad = 1;
      if (zs_start || fs_start) begin
         if (zs_start) n_zs++;
         if (fs_start) n_fs++;
         if (!rdy_n) rdy_start_bad = 1;
         in_cal = 1; ticks_since = 0;
      end
   endtask

   task automatic write_mode(input logic [1:0] m, input logic [1:0] c, input logic [2:0] g);
      mode_in = m; chan_in = c; gain_in = g; mode_wr = 1;
      cyc(0, 0);
      mode_wr = 0;
   endtask

   task automatic run_until_done();
      for (int i = 0; i < 400 && !done; i++) cyc(i % 4 == 3, 0);
   endtask

   task automatic settle_check(input string req);
      n_load = 0;
      for (int k = 1; k <= SETTLE; k++) begin
         cyc(1, 0); cyc(0, 0); cyc(0, 0); cyc(0, 0);
         if (k == SETTLE - 1) check(n_load == 0, {req, " no word before settling"}, n_load, 0);
      end
      check(n_load == 1, {req, " first word on settling tick"}, n_load, 1);
   endtask

   task automatic check_cal(input logic [1:0] m, input logic [1:0] c, input logic [2:0] g);
      check(done, "R2 calibration completes", done, 1);
      check(n_zs == int'(m != 2'b11), "R2 zero-scale strobe count", n_zs, int'(m != 2'b11));
      check(n_fs == int'(m != 2'b10), "R2 full-scale strobe count", n_fs, int'(m != 2'b10));
      check(n_wr == ((m == 2'b01) ? 2 : 1), "R5 coefficient write count", n_wr, (m == 2'b01) ? 2 : 1);
      check(wr_gain[0] == (m == 2'b11), "R5 first write kind", wr_gain[0], int'(m == 2'b11));
      check(wr_pair[0] == exp_pair(c), "R5 pair mapping", wr_pair[0], exp_pair(c));
      check(wr_val[0] == exp_val(m == 2'b11, g, c), "R6 first value", wr_val[0], exp_val(m == 2'b11, g, c));
      check(wr_ticks[0] == MEAS, "R2 ticks per measurement", wr_ticks[0], MEAS);
      if (m == 2'b01) begin
         check(wr_gain[1] == 1, "R5 second write is gain", wr_gain[1], 1);
         check(wr_val[1] == exp_val(1, g, c), "R6 second value", wr_val[1], exp_val(1, g, c));
         check(wr_ticks[1] == MEAS, "R2 ticks for full-scale step", wr_ticks[1], MEAS);
      end
      check(done_mode == 2'b00, "R4 mode clears on completion", done_mode, 0);
      check(!done_rdy && done_load, "R3 flag low with load at completion", done_rdy, 0);
      check(!rdy_start_bad && !rdy_mid_bad, "R3 flag high through calibration",
            int'(rdy_start_bad) + int'(rdy_mid_bad), 0);
      settle_check("R4");
   endtask

   task automatic run_cal(input logic [1:0] m, input logic [1:0] c, input logic [2:0] g);
      clear_tally();
      write_mode(m, c, g);
      run_until_done();
      check_cal(m, c, g);
   endtask

   initial begin : watchdog
      #(5.0 * 150000);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
         $finish;
      end
   end

   initial begin : main
      int unsigned seed;
      clear_tally();
      repeat (3) cyc(0, 0);
      // R1 reset state
      check(rdy_n == 1'b1, "R1 rdy_n after reset", rdy_n, 1);
      check(mode_out == 2'b00, "R1 mode after reset", mode_out, 0);
      check(!zs_start && !fs_start && !coef_wr && !dat_load, "R1 strobes idle after reset",
            int'(zs_start) + int'(fs_start) + int'(coef_wr) + int'(dat_load), 0);
      rst_n = 1;
      cyc(0, 0);

      // R8 normal conversion
      settle_check("R8");
      check(rdy_n == 1'b0, "R8 flag low after word", rdy_n, 0);
      cyc(0, 1);
      check(rdy_n == 1'b1, "R8 read clears flag", rdy_n, 1);
      cyc(1, 0);
      check(dat_load && !rdy_n, "R8 next tick loads word", rdy_n, 0);

      // R7 filter hold
      fsync = 1;
      n_load = 0;
      for (int k = 0; k < 4; k++) begin cyc(1, 0); cyc(0, 0); cyc(0, 0); end
      check(n_load == 0, "R7 no word during hold", n_load, 0);
      check(rdy_n == 1'b0, "R7 hold leaves low flag low", rdy_n, 0);
      clear_tally();
      write_mode(2'b10, 2'b01, 3'd3);
      for (int k = 0; k < 3; k++) begin cyc(1, 0); cyc(0, 0); cyc(0, 0); end
      check(n_zs == 0, "R7 calibration waits for hold release", n_zs, 0);
      fsync = 0;
      cyc(0, 0);
      check(n_zs == 1, "R7 calibration starts after release", n_zs, 1);
      run_until_done();
      check_cal(2'b10, 2'b01, 3'd3);

      // directed modes, shared pair for channel code 10
      run_cal(2'b01, 2'b10, 3'd0);
      run_cal(2'b11, 2'b00, 3'd7);
      run_cal(2'b01, 2'b11, 3'd5);

      // R9 abort
      clear_tally();
      write_mode(2'b01, 2'b01, 3'd2);
      cyc(0, 0); cyc(1, 0); cyc(0, 0); cyc(0, 0); cyc(0, 0); cyc(1, 0); cyc(0, 0);
      clear_tally();
      write_mode(2'b11, 2'b01, 3'd4);
      run_until_done();
      check(n_wr == 1 && wr_gain[0] == 1, "R9 aborted step writes nothing", n_wr, 1);
      check_cal(2'b11, 2'b01, 3'd4);

      // R10 standby
      clear_tally();
      write_mode(2'b10, 2'b11, 3'd2);
      cyc(0, 0);
      cyc(0, 0); cyc(1, 0); cyc(0, 0); cyc(0, 0); cyc(0, 0); cyc(1, 0);
      standby = 1;
      for (int k = 0; k < 6; k++) begin cyc(1, 0); cyc(0, 0); cyc(0, 0); end
      write_mode(2'b11, 2'b00, 3'd0);
      cyc(0, 0);
      check(mode_out == 2'b10, "R10 mode kept and write ignored", mode_out, 2);
      check(n_wr == 0, "R10 no write while frozen", n_wr, 0);
      check(rdy_n == 1'b1, "R10 flag held", rdy_n, 1);
      standby = 0;
      cyc(0, 0);
      run_until_done();
      check(wr_ticks[0] == MEAS, "R10 frozen ticks not counted", wr_ticks[0], MEAS);
      check_cal(2'b10, 2'b11, 3'd2);

      // constrained random runs
      seed = $urandom(32'd2024);
      for (int r = 0; r < 24; r++) begin
         logic [1:0] m, c;
         logic [2:0] g;
         m = 2'(1 + ($urandom % 3));
         c = 2'($urandom % 4);
         g = 3'($urandom % 8);
         run_cal(m, c, g);
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
   end

endmodule